// File: doc/BRIEF.md
# Dual-Ratio Synchronous Clock Divider

This block derives two slower clocks from one input clock. Output A runs at one half or one quarter of the input rate. Output B runs at one quarter, one fifth or one sixth of it. Both outputs come from dividers that advance on the same input rising edge and are reloaded at the same moment, so any rising edge the two outputs share falls on the same input edge. Every ratio has a 50% duty cycle. For the divide-by-5 ratio the high phase ends on an input falling edge.

An active-low run input is captured on the input falling edge. As a result, the dividers can only start or stop while the input clock is low, and a short pulse on that input while the clock is high has no effect. An asynchronous master reset forces both outputs low and returns both dividers to their start phase. Ratio selections are loaded on the first advancing edge after reset. After that they are loaded only where both outputs finish a period together, so no output period is ever cut short or stretched.

Top module: `dual_ratio_divider`

## Requirements
- R1: `selA` = 0 makes `divA` divide by 2 and `selA` = 1 makes it divide by 4. The duty cycle is 50%, with the high phase first in each period.
- R2: `selB` = 2'b00 makes `divB` divide by 4, 2'b01 divide by 6, and both 2'b10 and 2'b11 divide by 5. The high phase comes first in each period.
- R3: After reset is released, both outputs rise on the first input rising edge preceded by a falling edge at which `runN` was 0. While running, both dividers advance on every input rising edge.
- R4: If `runN` is 1 at an input falling edge, the following rising edge does not advance either divider, and both outputs keep their levels.
- R5: `runN` is sampled only at input falling edges. A pulse on `runN` that starts and ends while the input clock is high has no effect on the outputs.
- R6: While `mrst` is 1, both outputs are 0 at once, without waiting for a clock edge. After release, both dividers restart from the start phase of R3.
- R7: Divide-by-5 is high for exactly 5 input half-periods out of 10: it rises on a rising edge and falls on a falling edge. Even ratios N are high for N/2 whole input periods.
- R8: A change of `selA` or `selB` takes effect only at the next advancing edge where both outputs complete a period at the same time, that is, every LCM(ratioA, ratioB) advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Input clock; both dividers count its rising edges |
| mrst | input | 1 | Asynchronous master reset, active high |
| runN | input | 1 | Active-low run control, sampled on clkIn falling edge |
| selA | input | 1 | Ratio select for divA |
| selB | input | 2 | Ratio select for divB |
| divA | output | 1 | Divided clock, ratio 2 or 4 |
| divB | output | 1 | Divided clock, ratio 4, 5 or 6 |

## Verification
A wrong counter value or a wrong ratio register shows up within one output period. It appears as a high or low phase of the wrong length, or as a rising edge on the wrong input edge. A bad falling-edge copy in the odd divider changes divB by exactly one half input period on the next high phase. A wrong joint-wrap decision only shows when a selection changes mid-period, as a shortened period right after the change. The bench therefore samples both outputs on every half input period. It compares each sample with an arithmetic phase model, using all eight selection codes, hold stretches, high-phase pulses on `runN`, a reset in mid-run and selection changes in mid-period.

// File: rtl/divpair_pkg.sv
package divpair_pkg;
  localparam int DIV_CW = 3;

  typedef struct packed {
    logic adv;   // dividers step on this rising edge
    logic load;  // ratios reload and counters restart
  } divStrobe_t;

  function automatic int unsigned ratioForA(input logic sel);
    return sel ? 4 : 2;
  endfunction

  function automatic int unsigned ratioForB(input logic [1:0] sel);
    if (sel[1]) return 5;
    return sel[0] ? 6 : 4;
  endfunction
endpackage

// File: rtl/divpair_lane.sv
module divpair_lane #(
  parameter int CNT_W  = divpair_pkg::DIV_CW,
  parameter bit ODD_OK = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             load,
  input  logic [CNT_W-1:0] ratioIn,
  output logic             last,
  output logic             clkOut
);
  logic [CNT_W-1:0] ratQ, cntQ, ratN, cntN;
  logic posQ;

  assign last = (cntQ == ratQ - 1'b1);

  always_comb begin
    ratN = load ? ratioIn : ratQ;
    if (load || last) cntN = '0;
    else              cntN = cntQ + 1'b1;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ratQ <= CNT_W'(2);
      cntQ <= '0;
      posQ <= 1'b0;
    end else if (adv) begin
      ratQ <= ratN;
      cntQ <= cntN;
      posQ <= (cntN < (ratN >> 1));
    end
  end

  generate
    if (ODD_OK) begin : g_odd
      logic negQ;
      // half-period extension for odd ratios
      always_ff @(negedge clk or posedge rst) begin
        if (rst) negQ <= 1'b0;
        else     negQ <= posQ & ratQ[0];
      end
      assign clkOut = posQ | negQ;
    end else begin : g_even
      assign clkOut = posQ;
    end
  endgenerate
endmodule

// File: rtl/divpair_ctrl.sv
module divpair_ctrl (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     runN,
  input  logic                     atJoint,
  output divpair_pkg::divStrobe_t  strobe
);
  logic runQ, startQ;

  // run control retimed on the falling edge
  always_ff @(negedge clk or posedge rst) begin
    if (rst) runQ <= 1'b0;
    else     runQ <= ~runN;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)       startQ <= 1'b1;
    else if (runQ) startQ <= 1'b0;
  end

  always_comb begin
    strobe.adv  = runQ;
    strobe.load = runQ & (startQ | atJoint);
  end
endmodule

// File: rtl/divpair_path.sv
module divpair_path #(
  parameter int CNT_W = divpair_pkg::DIV_CW
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    selA,
  input  logic [1:0]              selB,
  input  divpair_pkg::divStrobe_t strobe,
  output logic                    atJoint,
  output logic                    divA,
  output logic                    divB
);
  localparam int LANES = 2;

  logic [CNT_W-1:0] ratioV [LANES];
  logic [LANES-1:0] lastV, clkV;

  assign ratioV[0] = CNT_W'(divpair_pkg::ratioForA(selA));
  assign ratioV[1] = CNT_W'(divpair_pkg::ratioForB(selB));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    divpair_lane #(.CNT_W(CNT_W), .ODD_OK(i == 1)) lane_i (
      .clk    (clk),
      .rst    (rst),
      .adv    (strobe.adv),
      .load   (strobe.load),
      .ratioIn(ratioV[i]),
      .last   (lastV[i]),
      .clkOut (clkV[i])
    );
  end

  assign atJoint = &lastV;
  assign divA    = clkV[0];
  assign divB    = clkV[1];
endmodule

// File: rtl/dual_ratio_divider.sv
module dual_ratio_divider #(
  parameter int CNT_W = divpair_pkg::DIV_CW
) (
  input  logic       clkIn,
  input  logic       mrst,
  input  logic       runN,
  input  logic       selA,
  input  logic [1:0] selB,
  output logic       divA,
  output logic       divB
);
  divpair_pkg::divStrobe_t strobe;
  logic atJoint;

  divpair_ctrl ctrl_i (
    .clk    (clkIn),
    .rst    (mrst),
    .runN   (runN),
    .atJoint(atJoint),
    .strobe (strobe)
  );

  divpair_path #(.CNT_W(CNT_W)) path_i (
    .clk    (clkIn),
    .rst    (mrst),
    .selA   (selA),
    .selB   (selB),
    .strobe (strobe),
    .atJoint(atJoint),
    .divA   (divA),
    .divB   (divB)
  );
endmodule

// File: rtl/divpair_chk.sv
module divpair_chk (
  input logic clkIn,
  input logic mrst,
  input logic runN,
  input logic divA,
  input logic divB
);
  logic holdCap;
  logic [2:0] runA, runB;

  always_ff @(negedge clkIn or posedge mrst) begin
    if (mrst) holdCap <= 1'b1;
    else      holdCap <= runN;
  end

  // consecutive advancing edges seen with each output high
  always_ff @(posedge clkIn or posedge mrst) begin
    if (mrst) begin
      runA <= '0;
      runB <= '0;
    end else if (!holdCap) begin
      runA <= divA ? runA + 3'd1 : 3'd0;
      runB <= divB ? runB + 3'd1 : 3'd0;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clkIn) mrst |-> (!divA && !divB)); // R6
  AST_HOLD_A: assert property (@(posedge clkIn) disable iff (mrst) holdCap |=> $stable(divA)); // R4
  AST_HOLD_B: assert property (@(posedge clkIn) disable iff (mrst) holdCap |=> $stable(divB)); // R4
  AST_HIGH_A_MAX: assert property (@(posedge clkIn) disable iff (mrst) runA <= 3'd2); // R1
  AST_HIGH_B_MAX: assert property (@(posedge clkIn) disable iff (mrst) runB <= 3'd3); // R7
endmodule

bind dual_ratio_divider divpair_chk chk_i (
  .clkIn(clkIn),
  .mrst (mrst),
  .runN (runN),
  .divA (divA),
  .divB (divB)
);

// File: tb/dual_ratio_divider_tb_top.sv
module dual_ratio_divider_tb_top;
  logic clkIn = 1'b0;
  logic mrst = 1'b1;
  logic runN = 1'b1;
  logic selA = 1'b0;
  logic [1:0] selB = 2'b00;
  logic divA, divB;

  int nChecks = 0;
  int nFail = 0;
  int segAdv = 0;
  int curA = 2, curB = 4, curL = 4;
  bit advThis = 1'b0;

  always #10 clkIn = ~clkIn;

  dual_ratio_divider dut_i (
    .clkIn(clkIn), .mrst(mrst), .runN(runN),
    .selA(selA), .selB(selB), .divA(divA), .divB(divB)
  );

  function automatic int lcmOf(input int a, input int b);
    for (int m = a; m <= a * b; m += a)
      if (m % b == 0) return m;
    return a * b;
  endfunction

  function automatic int ratioA(input logic s);
    return s ? 4 : 2;
  endfunction

  function automatic int ratioB(input logic [1:0] s);
    if (s[1]) return 5;
    return s[0] ? 6 : 4;
  endfunction

  // t counts input half-periods since the segment start
  function automatic logic waveAt(input int t, input int n);
    return (t % (2 * n)) < n;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkBoth(input string req, input bit oddHalf);
    logic ea, eb;
    int t;
    if (segAdv == 0) begin
      ea = 1'b0; eb = 1'b0;
    end else begin
      t = 2 * (segAdv - 1) + ((oddHalf || !advThis) ? 1 : 0);
      ea = waveAt(t, curA);
      eb = waveAt(t, curB);
    end
    check({req, " divA"}, divA, ea);
    check({req, " divB"}, divB, eb);
  endtask

  // entered and left at rising edge + 3 ns
  task automatic step(input logic e, input bit glitch, input string req);
    #2;
    runN = e;
    if (glitch) begin
      runN = ~e; #2; runN = e;
    end
    @(negedge clkIn); #3;
    checkBoth(req, 1'b1);
    @(posedge clkIn);
    advThis = (e == 1'b0);
    if (advThis) begin
      if (segAdv == 0 || segAdv == curL) begin
        curA = ratioA(selA); curB = ratioB(selB);
        curL = lcmOf(curA, curB); segAdv = 1;
      end else segAdv++;
    end
    #3;
    checkBoth(req, 1'b0);
  endtask

  task automatic doReset();
    mrst = 1'b1; runN = 1'b1;
    #1;
    check("R6 async divA", divA, 1'b0);
    check("R6 async divB", divB, 1'b0);
    @(posedge clkIn); #5;
    mrst = 1'b0;
    segAdv = 0; advThis = 1'b0;
    @(posedge clkIn); #3;
  endtask

  initial begin
    #(20 * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    @(posedge clkIn); #3;
    check("R6 reset divA", divA, 1'b0);
    check("R6 reset divB", divB, 1'b0);

    // R1 R2 R3 R7: every selection code, free running
    for (int a = 0; a < 2; a++) begin
      for (int b = 0; b < 4; b++) begin
        selA = a[0]; selB = b[1:0];
        doReset();
        step(1'b0, 1'b0, "R3 first edge");
        for (int k = 0; k < 2 * lcmOf(ratioA(a[0]), ratioB(b[1:0])) + 3; k++)
          step(1'b0, 1'b0, (b >= 2) ? "R7 odd duty" : (a == 1 ? "R1 ratio" : "R2 ratio"));
      end
    end

    // R4 hold and R5 high-phase pulses on runN
    selA = 1'b1; selB = 2'b10;
    doReset();
    for (int k = 0; k < 7; k++) step(1'b0, 1'b0, "R3 run");
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, "R4 hold");
    for (int k = 0; k < 6; k++) step(1'b0, 1'b1, "R5 pulse while running");
    for (int k = 0; k < 3; k++) step(1'b1, 1'b1, "R5 pulse while held");
    for (int k = 0; k < 25; k++) step(1'b0, 1'b0, "R4 resume");

    // R8 selection changes in mid-period
    selA = 1'b0; selB = 2'b01;
    doReset();
    for (int k = 0; k < 5; k++) step(1'b0, 1'b0, "R8 before change");
    selA = 1'b1; selB = 2'b11;
    for (int k = 0; k < 30; k++) step(1'b0, 1'b0, "R8 after change");
    selB = 2'b00;
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, "R8 held");
    for (int k = 0; k < 30; k++) step(1'b0, 1'b0, "R8 second change");

    // R6 reset in mid-run, then restart
    selA = 1'b0; selB = 2'b10;
    doReset();
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, "R3 run");
    doReset();
    for (int k = 0; k < 22; k++) step(1'b0, 1'b0, "R6 restart");

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule